// File: doc/BRIEF.md
# SD card one-bit command engine

This block lets a processor drive an SD card over its one-bit native bus through a small set of word registers. Software first writes the six bytes of a card command into byte registers. It then writes a short operation code to a command register. From there the engine runs on its own. It generates the card clock by dividing the system clock, and it does one of the following:

- shifts the 48-bit command out on CMD;
- hunts for the start bit of a response and captures the first response byte;
- captures one further response byte;
- reads a 512-byte data block from DAT0 into an internal word buffer;
- issues a burst of dummy clocks.

Software polls a status register. It reads zero while an operation runs, one when the operation has completed, and three when a response never started. Each response byte and each buffered data word is read back by word address. Card initialisation policy, command CRC generation, wide data mode and block writes are left to software or to other blocks.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset, status reads 1, the card clock is low, CMD is released (drive enable 0, CMD output 1) and the response byte reads 0.
- R2: Word offsets are as follows. Offsets 0 to 127 read buffer words. Offset 0x81 is the operation register. Offset 0x82 reads the response byte in bits 7:0. Offset 0x84 reads the status in bits 1:0. Offsets 0x88 to 0x8D are command bytes 0 to 5, written from bits 7:0. Every other offset, the command byte offsets included, reads 0.
- R3: An operation register write is accepted only while the engine is idle, and only with a code from 1 to 7 in bits 2:0 and zeros above. An accepted write makes status read 0 from the next cycle on. Any other write, including one made while busy, changes neither status nor the card pins.
- R4: Code 1 drives CMD at once with command byte 0 bit 7 first, the bytes running 0 to 5 and each MSB first. The next bit appears at each card-clock falling edge. After exactly 48 card clocks, CMD is released and status becomes 1.
- R5: Code 6 samples CMD at each card-clock rising edge until it reads low. That low bit and the following 7 bits form the response byte, MSB first. Status then becomes 1, after start-position plus 8 card clocks in total.
- R6: If code 6 sees CMD high on 64 consecutive rising edges, status becomes 3 after exactly 64 card clocks, and the response byte keeps its old value.
- R7: Code 2 captures the next 8 CMD bits, MSB first, from its first rising edge into the response byte. It takes exactly 8 card clocks and status becomes 1.
- R8: Code 3 waits for DAT0 low at a rising edge. It then stores the next 4096 bits as 128 words, with the first bit landing in word 0 bit 31. It clocks 17 further bits without checking them, after which status becomes 1.
- R9: Codes 4 and 5 each give exactly 8 card clocks with CMD released and then set status to 1.
- R10: Code 7 gives no card clock and leaves CMD released. Status reads 0 for one cycle and then 1.
- R11: The card clock has a period of 2*HALF_DIV system cycles while an operation runs, and it is low whenever status is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word offset for both reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, available in the same cycle |
| sd_clk_o | output | 1 | Card clock |
| sd_cmd_o | output | 1 | CMD output value (1 when released) |
| sd_cmd_oe_o | output | 1 | CMD drive enable |
| sd_cmd_i | input | 1 | CMD input from the card |
| sd_dat0_i | input | 1 | DAT0 input from the card |

## Verification
Status changes to 0 on the first system edge after an accepted operation write. The bench reads it at the falling system edge that follows. Code 7 is the exception: its status returns to 1 one cycle later, and the bench checks that too. Every other operation ends on the card-clock falling edge after its last clock. The bench therefore polls status once per cycle and judges each operation by the number of card-clock rising edges it counted, not by absolute cycle numbers. Card-side bits are captured, and the card model changes its inputs, only at falling system edges that follow a card-clock transition. Each new value is thus stable at least one system cycle before the engine samples it.

// File: rtl/sd_eng_pkg.sv
package sd_eng_pkg;
  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_SEND      = 3'd1,
    OP_RSP_BYTE  = 3'd2,
    OP_BLOCK     = 3'd3,
    OP_DUMMY_RSP = 3'd4,
    OP_DUMMY_BLK = 3'd5,
    OP_PROBE     = 3'd6,
    OP_IDLE_LVL  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_BUSY    = 2'd0,
    ST_DONE    = 2'd1,
    ST_TIMEOUT = 2'd3
  } status_e;

  typedef enum logic [3:0] {
    S_IDLE, S_INIT, S_TX, S_PROBE, S_RX, S_DWAIT, S_DBITS, S_DTAIL, S_DUMMY, S_FINISH
  } fsm_e;
endpackage

// File: rtl/sd_clk_div.sv
module sd_clk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sd_clk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          clk_q;
  logic          wrap;

  assign wrap     = run_i && (cnt_q == CW'(HALF_DIV - 1));
  assign rise_o   = wrap && !clk_q;
  assign fall_o   = wrap && clk_q;
  assign sd_clk_o = clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx #(
  parameter int FRAME_W = 48
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               shift_i,
  output logic               bit_o
);
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '1;
    else if (load_i)  sr_q <= frame_i;
    else if (shift_i) sr_q <= {sr_q[FRAME_W-2:0], 1'b1};
  end

  assign bit_o = sr_q[FRAME_W-1];
endmodule

// File: rtl/sd_blk_buf.sv
module sd_blk_buf #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     bit_vld_i,
  input  logic                     bit_i,
  input  logic [$clog2(WORDS)-1:0] rd_idx_i,
  output logic [WORD_W-1:0]        rd_data_o
);
  localparam int IW = $clog2(WORDS);
  localparam int BW = $clog2(WORD_W);

  logic [WORD_W-1:0] mem [WORDS];
  logic [WORD_W-2:0] acc_q;
  logic [BW-1:0]     bit_q;
  logic [IW:0]       idx_q;
  logic [WORD_W-1:0] acc_n;
  logic              word_end;

  assign acc_n    = {acc_q, bit_i};
  assign word_end = bit_vld_i && (bit_q == BW'(WORD_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      bit_q <= '0;
      idx_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      bit_q <= '0;
      idx_q <= '0;
    end else if (bit_vld_i) begin
      acc_q <= acc_n[WORD_W-2:0];
      bit_q <= word_end ? '0 : bit_q + BW'(1);
      if (word_end) idx_q <= idx_q + (IW+1)'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (word_end) mem[idx_q[IW-1:0]] <= acc_n;
  end

  assign rd_data_o = mem[rd_idx_i];

  // R8
  buf_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_i |-> (idx_q < (IW+1)'(WORDS)));
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_eng_pkg::*;
#(
  parameter int HALF_DIV       = 2,
  parameter int ADDR_W         = 8,
  parameter int BLK_WORDS      = 128,
  parameter int RSP_WAIT_CLKS  = 64,
  parameter int DUMMY_RSP_CLKS = 8,
  parameter int DUMMY_BLK_CLKS = 8,
  parameter int TAIL_CLKS      = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sd_clk_o,
  output logic              sd_cmd_o,
  output logic              sd_cmd_oe_o,
  input  logic              sd_cmd_i,
  input  logic              sd_dat0_i
);
  localparam int WORD_W    = 32;
  localparam int CMD_BYTES = 6;
  localparam int FRAME_W   = 8 * CMD_BYTES;
  localparam int BLK_BITS  = BLK_WORDS * WORD_W;
  localparam int IW        = $clog2(BLK_WORDS);
  localparam int CW        = $clog2(BLK_BITS + 1);
  localparam logic [ADDR_W-1:0] OFS_OP   = ADDR_W'(8'h81);
  localparam logic [ADDR_W-1:0] OFS_RSP  = ADDR_W'(8'h82);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(8'h84);
  localparam int                OFS_CMD0 = 8'h88;

  fsm_e          state_q;
  status_e       st_q, fin_q;
  logic [7:0]    rsp_q;
  logic [6:0]    rx_sr_q;
  logic [7:0]    rx_nb;
  logic [CW-1:0] cnt_q, dlim_q;
  logic          oe_q;
  logic [7:0]    cmd_b [CMD_BYTES];
  logic [FRAME_W-1:0] frame;

  logic op_wr, accept, run, rise, fall, tx_bit, tx_shift, buf_clr, buf_vld;
  logic [WORD_W-1:0] buf_word;
  op_e  op_in;

  assign op_wr  = we_i && (addr_i == OFS_OP);
  assign op_in  = op_e'(wdata_i[2:0]);
  assign accept = op_wr && (state_q == S_IDLE) && (wdata_i[31:3] == '0) && (op_in != OP_NONE);
  assign run    = (state_q != S_IDLE) && (state_q != S_INIT);
  assign rx_nb  = {rx_sr_q, sd_cmd_i};

  for (genvar g = 0; g < CMD_BYTES; g++) begin : g_frame
    assign frame[FRAME_W-1-8*g -: 8] = cmd_b[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CMD_BYTES; i++) cmd_b[i] <= '0;
    end else begin
      for (int i = 0; i < CMD_BYTES; i++)
        if (we_i && (addr_i == ADDR_W'(OFS_CMD0 + i))) cmd_b[i] <= wdata_i[7:0];
    end
  end

  sd_clk_div #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk_i, .rst_ni, .run_i(run), .sd_clk_o, .rise_o(rise), .fall_o(fall)
  );

  assign tx_shift = (state_q == S_TX) && fall;

  sd_cmd_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk_i, .rst_ni, .load_i(accept && (op_in == OP_SEND)), .frame_i(frame),
    .shift_i(tx_shift), .bit_o(tx_bit)
  );

  assign buf_clr = accept && (op_in == OP_BLOCK);
  assign buf_vld = (state_q == S_DBITS) && rise;

  sd_blk_buf #(.WORDS(BLK_WORDS), .WORD_W(WORD_W)) u_buf (
    .clk_i, .rst_ni, .clr_i(buf_clr), .bit_vld_i(buf_vld), .bit_i(sd_dat0_i),
    .rd_idx_i(addr_i[IW-1:0]), .rd_data_o(buf_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      st_q    <= ST_DONE;
      fin_q   <= ST_DONE;
      rsp_q   <= '0;
      rx_sr_q <= '0;
      cnt_q   <= '0;
      dlim_q  <= '0;
      oe_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          st_q  <= ST_BUSY;
          cnt_q <= '0;
          case (op_in)
            OP_SEND:      begin oe_q <= 1'b1; state_q <= S_TX; end
            OP_RSP_BYTE:  state_q <= S_RX;
            OP_BLOCK:     state_q <= S_DWAIT;
            OP_DUMMY_RSP: begin dlim_q <= CW'(DUMMY_RSP_CLKS - 1); state_q <= S_DUMMY; end
            OP_DUMMY_BLK: begin dlim_q <= CW'(DUMMY_BLK_CLKS - 1); state_q <= S_DUMMY; end
            OP_PROBE:     state_q <= S_PROBE;
            default:      state_q <= S_INIT;
          endcase
        end
        S_INIT: begin
          state_q <= S_IDLE;
          st_q    <= ST_DONE;
        end
        S_TX: if (fall) begin
          if (cnt_q == CW'(FRAME_W - 1)) begin
            oe_q    <= 1'b0;
            st_q    <= ST_DONE;
            state_q <= S_IDLE;
          end else cnt_q <= cnt_q + CW'(1);
        end
        S_PROBE: if (rise) begin
          if (!sd_cmd_i) begin
            rx_sr_q <= rx_nb[6:0];
            cnt_q   <= CW'(1);
            state_q <= S_RX;
          end else if (cnt_q == CW'(RSP_WAIT_CLKS - 1)) begin
            fin_q   <= ST_TIMEOUT;
            state_q <= S_FINISH;
          end else cnt_q <= cnt_q + CW'(1);
        end
        S_RX: if (rise) begin
          rx_sr_q <= rx_nb[6:0];
          if (cnt_q == CW'(7)) begin
            rsp_q   <= rx_nb;
            fin_q   <= ST_DONE;
            state_q <= S_FINISH;
          end else cnt_q <= cnt_q + CW'(1);
        end
        S_DWAIT: if (rise && !sd_dat0_i) begin
          cnt_q   <= '0;
          state_q <= S_DBITS;
        end
        S_DBITS: if (rise) begin
          if (cnt_q == CW'(BLK_BITS - 1)) begin
            cnt_q   <= '0;
            state_q <= S_DTAIL;
          end else cnt_q <= cnt_q + CW'(1);
        end
        S_DTAIL: if (rise) begin
          if (cnt_q == CW'(TAIL_CLKS - 1)) begin
            fin_q   <= ST_DONE;
            state_q <= S_FINISH;
          end else cnt_q <= cnt_q + CW'(1);
        end
        S_DUMMY: if (fall) begin
          if (cnt_q == dlim_q) begin
            st_q    <= ST_DONE;
            state_q <= S_IDLE;
          end else cnt_q <= cnt_q + CW'(1);
        end
        S_FINISH: if (fall) begin
          st_q    <= fin_q;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign sd_cmd_oe_o = oe_q;
  assign sd_cmd_o    = oe_q ? tx_bit : 1'b1;

  always_comb begin
    rdata_o = '0;
    if (addr_i < ADDR_W'(BLK_WORDS)) rdata_o = buf_word;
    else if (addr_i == OFS_RSP)      rdata_o = {24'b0, rsp_q};
    else if (addr_i == OFS_STAT)     rdata_o = {30'b0, st_q};
  end

  // R11
  idle_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_BUSY) |-> !sd_clk_o);
  // R6
  status_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BUSY) || (st_q == ST_DONE) || (st_q == ST_TIMEOUT));
  // R4
  drive_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_cmd_oe_o |-> (st_q == ST_BUSY));
  // R3
  accept_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (st_q == ST_BUSY));
  // R4
  cmd_hold_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> $stable(sd_cmd_o));
endmodule

// File: tb/sd_cmd_engine_bench.sv
module sd_cmd_engine_bench;
  localparam int CLK_NS = 10;
  localparam int HALF   = 2;
  localparam int NBITS  = 4096;

  typedef struct packed { logic [7:0] lead; logic [15:0] frame; } pv_t;
  localparam pv_t PV [4] = '{
    '{8'd0,  16'h3FA5},
    '{8'd5,  16'h11C3},
    '{8'd63, 16'h00FF},
    '{8'd64, 16'h2A55}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire  sd_clk, sd_cmd, sd_cmd_oe;
  logic sd_cmd_in = 1'b1;
  logic sd_dat0 = 1'b1;

  int checks = 0, errors = 0;
  int rises = 0, cyc = 0, last_rise = 0, period = 0;
  logic clk_prev = 1'b0;
  int cm_lead = 100000, cm_base = 0, dm_lead = 100000, dm_base = 0;
  logic [15:0] cm_frame = '1;
  logic [47:0] tx_cap = '0;
  int tx_n = 0;
  bit ended = 0;

  always #(CLK_NS/2) clk = ~clk;

  sd_cmd_engine u_sd_cmd_engine (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sd_clk_o(sd_clk), .sd_cmd_o(sd_cmd), .sd_cmd_oe_o(sd_cmd_oe),
    .sd_cmd_i(sd_cmd_in), .sd_dat0_i(sd_dat0)
  );

  function automatic logic [31:0] dword(int j);
    logic [31:0] v;
    v = 32'(j + 1) * 32'h9E3779B9;
    return v;
  endfunction

  function automatic logic cmd_val(int k);
    if (k < cm_lead) return 1'b1;
    if (k - cm_lead < 16) return cm_frame[15 - (k - cm_lead)];
    return 1'b1;
  endfunction

  function automatic logic dat_val(int k);
    int j;
    logic [31:0] w;
    if (k < dm_lead) return 1'b1;
    if (k == dm_lead) return 1'b0;
    j = k - dm_lead - 1;
    if (j < NBITS) begin
      w = dword(j / 32);
      return w[31 - (j % 32)];
    end
    return 1'b1;
  endfunction

  // card model and monitor, acting between system clock edges
  always @(negedge clk) begin
    cyc++;
    if (sd_clk && !clk_prev) begin
      rises++;
      period = cyc - last_rise;
      last_rise = cyc;
      if (sd_cmd_oe) begin
        tx_cap = {tx_cap[46:0], sd_cmd};
        tx_n++;
      end
    end
    if (!sd_clk && clk_prev) begin
      sd_cmd_in = cmd_val(rises - cm_base);
      sd_dat0   = dat_val(rises - dm_base);
    end
    clk_prev = sd_clk;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_done(output logic [31:0] st);
    bit got = 0;
    st = '0;
    for (int n = 0; n < 40000 && !got; n++) begin
      rd(8'h84, st);
      if (st != 0) got = 1;
      else @(negedge clk);
    end
  endtask

  task automatic arm_cmd(int lead, logic [15:0] fr);
    cm_lead = lead; cm_frame = fr; cm_base = rises;
    sd_cmd_in = cmd_val(0);
  endtask

  task automatic summary;
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic send_frame(logic [47:0] fr, string tag);
    logic [31:0] v;
    int r0;
    for (int i = 0; i < 6; i++) wr(8'h88 + 8'(i), {24'b0, fr[47-8*i -: 8]});
    r0 = rises; tx_n = 0;
    wr(8'h81, 32'd1);
    rd(8'h84, v);
    chk({"R3 status cleared ", tag}, v, 0);
    chk({"R4 drive on ", tag}, sd_cmd_oe, 1);
    chk({"R4 first bit ", tag}, sd_cmd, fr[47]);
    wr(8'h81, 32'd4);
    wait_done(v);
    chk({"R4 status ", tag}, v, 1);
    chk({"R4 frame ", tag}, tx_cap, fr);
    chk({"R4 bit count ", tag}, tx_n, 48);
    chk({"R4 clocks ", tag}, rises - r0, 48);
    chk({"R4 released ", tag}, {sd_cmd_oe, sd_cmd}, 2'b01);
    repeat (30) @(negedge clk);
    chk({"R3 busy write ignored ", tag}, rises - r0, 48);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [7:0] prev_rsp;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    rd(8'h84, v); chk("R1 status", v, 1);
    rd(8'h82, v); chk("R1 response", v, 0);
    chk("R1 clock low", sd_clk, 0);
    chk("R1 cmd released", {sd_cmd_oe, sd_cmd}, 2'b01);

    // R2
    rd(8'h90, v); chk("R2 unmapped", v, 0);
    wr(8'h8A, 32'h5A);
    rd(8'h8A, v); chk("R2 command byte reads 0", v, 0);

    send_frame(48'h401234567895, "A");
    send_frame(48'h7F00FFAA5501, "B");

    // R3: invalid code and nonzero upper bits
    r0 = rises;
    wr(8'h81, 32'd0);
    rd(8'h84, v); chk("R3 code 0 ignored", v, 1);
    wr(8'h81, 32'h0000_0104);
    rd(8'h84, v); chk("R3 upper bits ignored", v, 1);
    repeat (20) @(negedge clk);
    chk("R3 no clocks", rises - r0, 0);

    // R5 R6 R7 table
    prev_rsp = 8'h00;
    for (int i = 0; i < 4; i++) begin
      arm_cmd(int'(PV[i].lead), PV[i].frame);
      r0 = rises;
      wr(8'h81, 32'd6);
      wait_done(v);
      if (PV[i].lead < 64) begin
        chk("R5 probe status", v, 1);
        chk("R5 probe clocks", rises - r0, int'(PV[i].lead) + 8);
        rd(8'h82, v); chk("R5 probe byte", v, {24'b0, PV[i].frame[15:8]});
        r0 = rises;
        wr(8'h81, 32'd2);
        wait_done(v);
        chk("R7 byte status", v, 1);
        chk("R7 byte clocks", rises - r0, 8);
        rd(8'h82, v); chk("R7 next byte", v, {24'b0, PV[i].frame[7:0]});
        prev_rsp = PV[i].frame[7:0];
      end else begin
        chk("R6 timeout status", v, 3);
        chk("R6 timeout clocks", rises - r0, 64);
        rd(8'h82, v); chk("R6 response kept", v, {24'b0, prev_rsp});
      end
      chk("R11 clock low at end", sd_clk, 0);
    end

    // R9
    for (int c = 4; c <= 5; c++) begin
      r0 = rises;
      wr(8'h81, 32'(c));
      rd(8'h84, v); chk("R9 status cleared", v, 0);
      wait_done(v);
      chk("R9 status", v, 1);
      chk("R9 clocks", rises - r0, 8);
      chk("R11 period", period, 2 * HALF);
      chk("R9 cmd released", {sd_cmd_oe, sd_cmd}, 2'b01);
    end

    // R10
    r0 = rises;
    wr(8'h81, 32'd7);
    rd(8'h84, v); chk("R10 busy one cycle", v, 0);
    @(negedge clk);
    rd(8'h84, v); chk("R10 done", v, 1);
    chk("R10 no clocks", rises - r0, 0);
    chk("R10 cmd released", {sd_cmd_oe, sd_cmd}, 2'b01);

    // R8
    dm_lead = 10; dm_base = rises;
    sd_dat0 = dat_val(0);
    r0 = rises;
    wr(8'h81, 32'd3);
    wait_done(v);
    chk("R8 status", v, 1);
    chk("R8 clocks", rises - r0, 10 + 1 + NBITS + 17);
    chk("R11 period block", period, 2 * HALF);
    for (int w = 0; w < 128; w++) begin
      rd(8'(w), v);
      chk("R8 buffer word", v, dword(w));
    end
    rd(8'h84, v); chk("R2 status after buffer reads", v, 1);

    summary();
  end
endmodule